// File: doc/BRIEF.md
# PTP Event Frame Timestamp Capture Latch

This block records the value of the free-running time counter at the moment a precision-time event frame starts on the transmit or the receive path. Each direction owns one capture slot. When a qualifying start-of-frame strobe arrives, the slot copies the time counter in that same cycle, raises its valid flag and locks. A locked slot ignores every later frame until software collects the value through a word-wide read port, which offers the 64-bit capture as a low and a high word. Reading the high word releases the lock. Reading only the high word is enough to free a slot whose frame was lost.

Each slot is a three-state machine. `SLOT_OFF` is entered from any state when the direction's enable input is low, and that transition drops a pending valid flag. `SLOT_OFF` goes to `SLOT_ARMED` on the first cycle the enable is high. `SLOT_ARMED` goes to `SLOT_HELD` on a qualifying strobe, capturing the time counter. `SLOT_HELD` goes back to `SLOT_ARMED` when the slot's high word is read. On transmit, a frame qualifies when the MAC marks it for stamping. On receive, a frame qualifies according to a mode field, which can select version-1 event messages over UDP, version-2 event messages at Layer 2 or over UDP, every frame, or no frame. The Layer 2 filter matches on an ethertype. The UDP filter matches on the destination port, and optionally on the source port as well.

Top module: `ptp_stamp_latch`

## Requirements
- R1: After reset both valid flags are 0, and every read word returns 0.
- R2: With `tx_en` high, a `tx_sof` pulse with `tx_stamp_req` high captures `time_now` from that same clock edge, and `tx_valid` is 1 one cycle later. A `tx_sof` pulse with `tx_stamp_req` low captures nothing.
- R3: While a slot is valid, further qualifying strobes are dropped and the captured value stays unchanged.
- R4: `rd_sel` maps the words as follows: 0 is TX bits 31:0, 1 is TX bits 63:32, 2 is RX bits 31:0 and 3 is RX bits 63:32. A read strobe (`rd_en`) on the high word of a slot clears that slot's valid flag on the next edge. A read strobe on the low word has no effect on the flag.
- R5: An enable that is low clears the slot's valid flag on the next edge, and no capture takes place while the enable is low. A slot begins to accept strobes one cycle after its enable rises.
- R6: In mode 1 (version-2 event), the Layer 2 filter qualifies a frame with ethertype 0x88F7 only when both `l2_filt_en` and `l2_filt_ts` are 1.
- R7: The UDP filter (`l4_filt_en`) qualifies only UDP frames with destination port 319. When `l4_src_chk` is 1, the source port must also be 319.
- R8: In mode 0 (version-1 over UDP), a frame qualifies only if it passes the UDP filter, its version is 1, and its message type equals `v1_msg_sel` (0 selects Sync, 1 selects Delay_Req).
- R9: In mode 1, only message types 0 to 3 with version 2 qualify. Other types, such as 8, are not stamped.
- R10: Mode 2 stamps every receive frame regardless of its fields. Mode 3 stamps none.
- R11: A high-word read strobe that coincides with a qualifying strobe releases the slot. The strobe is dropped, and the earlier capture stays readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_now | input | 64 | Time counter value |
| tx_en | input | 1 | Transmit stamping enable |
| rx_en | input | 1 | Receive stamping enable |
| rx_mode | input | 2 | 0 = v1 over UDP, 1 = v2 event, 2 = all frames, 3 = none |
| v1_msg_sel | input | 1 | Version-1 message select: 0 = Sync, 1 = Delay_Req |
| l2_filt_en | input | 1 | Ethertype filter enable |
| l2_filt_ts | input | 1 | Ethertype filter timestamp permission |
| l4_filt_en | input | 1 | UDP port filter enable |
| l4_src_chk | input | 1 | Also require source port 319 |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| tx_stamp_req | input | 1 | Transmit frame is marked for stamping |
| rx_sof | input | 1 | Receive start-of-frame strobe |
| rx_ethertype | input | 16 | Receive frame ethertype |
| rx_is_udp | input | 1 | Receive frame carries UDP |
| rx_dst_port | input | 16 | UDP destination port |
| rx_src_port | input | 16 | UDP source port |
| rx_ptp_ver | input | 4 | PTP version field |
| rx_msg_type | input | 4 | PTP message type or v1 control field |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 2 | Word select (see R4) |
| rd_data | output | 32 | Selected capture word |
| tx_valid | output | 1 | Transmit capture held |
| rx_valid | output | 1 | Receive capture held |

## Verification
Receive frames are offered in two kinds of pattern. The first is a matching frame next to one that differs in a single field: the ethertype, a filter bit, the UDP flag, the source port, the version or the message type. Each such pair shows that this one term of the qualifier is honoured. Repeated strobes against a held slot separate locking from overwriting, and the capture words then show which time counter value was kept. Low-word reads, high-word reads and a high-word read that coincides with a new frame distinguish the release rule from a plain read.

// File: rtl/ptp_stamp_pkg.sv
package ptp_stamp_pkg;

    typedef enum logic [1:0] {
        SLOT_OFF   = 2'd0,
        SLOT_ARMED = 2'd1,
        SLOT_HELD  = 2'd2
    } slot_state_t;

    typedef enum logic [1:0] {
        RXM_V1_L4  = 2'd0,
        RXM_V2_EVT = 2'd1,
        RXM_ALL    = 2'd2,
        RXM_NONE   = 2'd3
    } rx_mode_t;

    localparam logic [15:0] PTP_ETHERTYPE  = 16'h88F7;
    localparam logic [15:0] PTP_EVENT_PORT = 16'd319;
    localparam int          DIR_TX         = 0;
    localparam int          DIR_RX         = 1;
    localparam int          NUM_DIR        = 2;

endpackage

// File: rtl/ptp_rx_qualifier.sv
module ptp_rx_qualifier
    import ptp_stamp_pkg::*;
#(
    parameter int PORT_W = 16,
    parameter int FIELD_W = 4
) (
    input  logic               sof,
    input  logic [1:0]         mode,
    input  logic               v1_msg_sel,
    input  logic               l2_en,
    input  logic               l2_ts,
    input  logic               l4_en,
    input  logic               l4_src_chk,
    input  logic [PORT_W-1:0]  ethertype,
    input  logic               is_udp,
    input  logic [PORT_W-1:0]  dst_port,
    input  logic [PORT_W-1:0]  src_port,
    input  logic [FIELD_W-1:0] ptp_ver,
    input  logic [FIELD_W-1:0] msg_type,
    output logic               hit
);
    localparam logic [FIELD_W-1:0] VER_ONE = FIELD_W'(1);
    localparam logic [FIELD_W-1:0] VER_TWO = FIELD_W'(2);
    localparam logic [FIELD_W-1:0] V2_EVT_LIMIT = FIELD_W'(4);

    logic l2_match;
    logic l4_match;
    logic v1_event;
    logic v2_event;
    logic sel_match;

    always_comb begin
        l2_match = l2_en && l2_ts && (ethertype == PTP_ETHERTYPE);
        l4_match = l4_en && is_udp && (dst_port == PTP_EVENT_PORT)
                   && (!l4_src_chk || (src_port == PTP_EVENT_PORT));
        v1_event = (ptp_ver == VER_ONE) && (msg_type == FIELD_W'(v1_msg_sel));
        v2_event = (ptp_ver == VER_TWO) && (msg_type < V2_EVT_LIMIT);
        unique case (rx_mode_t'(mode))
            RXM_V1_L4:  sel_match = l4_match && v1_event;
            RXM_V2_EVT: sel_match = (l2_match || l4_match) && v2_event;
            RXM_ALL:    sel_match = 1'b1;
            RXM_NONE:   sel_match = 1'b0;
            default:    sel_match = 1'b0;
        endcase
        hit = sof && sel_match;
    end

endmodule

// File: rtl/ptp_stamp_slot.sv
module ptp_stamp_slot
    import ptp_stamp_pkg::*;
#(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            hit,
    input  logic            release_i,
    input  logic [TS_W-1:0] time_i,
    output logic            valid_o,
    output logic [TS_W-1:0] cap_o
);
    slot_state_t state_q;
    slot_state_t state_d;
    logic        take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_OFF:   if (en) state_d = SLOT_ARMED;
            SLOT_ARMED: begin
                if (!en)      state_d = SLOT_OFF;
                else if (hit) state_d = SLOT_HELD;
            end
            SLOT_HELD: begin
                if (!en)            state_d = SLOT_OFF;
                else if (release_i) state_d = SLOT_ARMED;
            end
            default:    state_d = SLOT_OFF;
        endcase
    end

    always_comb begin
        valid_o = (state_q == SLOT_HELD);
        take    = (state_q == SLOT_ARMED) && en && hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cap_o <= '0;
        else if (take) cap_o <= time_i;
    end

endmodule

// File: rtl/ptp_stamp_latch.sv
module ptp_stamp_latch
    import ptp_stamp_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int PORT_W = 16,
    parameter int FIELD_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*WORD_W-1:0] time_now,
    input  logic                tx_en,
    input  logic                rx_en,
    input  logic [1:0]          rx_mode,
    input  logic                v1_msg_sel,
    input  logic                l2_filt_en,
    input  logic                l2_filt_ts,
    input  logic                l4_filt_en,
    input  logic                l4_src_chk,
    input  logic                tx_sof,
    input  logic                tx_stamp_req,
    input  logic                rx_sof,
    input  logic [PORT_W-1:0]   rx_ethertype,
    input  logic                rx_is_udp,
    input  logic [PORT_W-1:0]   rx_dst_port,
    input  logic [PORT_W-1:0]   rx_src_port,
    input  logic [FIELD_W-1:0]  rx_ptp_ver,
    input  logic [FIELD_W-1:0]  rx_msg_type,
    input  logic                rd_en,
    input  logic [1:0]          rd_sel,
    output logic [WORD_W-1:0]   rd_data,
    output logic                tx_valid,
    output logic                rx_valid
);
    localparam int TS_W = 2 * WORD_W;

    logic              rx_hit;
    logic              tx_hit;
    logic [NUM_DIR-1:0] dir_en;
    logic [NUM_DIR-1:0] dir_hit;
    logic [NUM_DIR-1:0] dir_rel;
    logic [NUM_DIR-1:0] dir_valid;
    logic [TS_W-1:0]    dir_cap [NUM_DIR];
    logic [TS_W-1:0]    tx_cap;
    logic [TS_W-1:0]    rx_cap;
    logic [TS_W-1:0]    sel_cap;

    ptp_rx_qualifier #(.PORT_W(PORT_W), .FIELD_W(FIELD_W)) i_rx_qual (
        .sof        (rx_sof),
        .mode       (rx_mode),
        .v1_msg_sel (v1_msg_sel),
        .l2_en      (l2_filt_en),
        .l2_ts      (l2_filt_ts),
        .l4_en      (l4_filt_en),
        .l4_src_chk (l4_src_chk),
        .ethertype  (rx_ethertype),
        .is_udp     (rx_is_udp),
        .dst_port   (rx_dst_port),
        .src_port   (rx_src_port),
        .ptp_ver    (rx_ptp_ver),
        .msg_type   (rx_msg_type),
        .hit        (rx_hit)
    );

    always_comb begin
        tx_hit          = tx_sof && tx_stamp_req;
        dir_en[DIR_TX]  = tx_en;
        dir_en[DIR_RX]  = rx_en;
        dir_hit[DIR_TX] = tx_hit;
        dir_hit[DIR_RX] = rx_hit;
    end

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_slot
        assign dir_rel[d] = rd_en && rd_sel[0] && (rd_sel[1] == 1'(d));
        ptp_stamp_slot #(.TS_W(TS_W)) i_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (dir_en[d]),
            .hit       (dir_hit[d]),
            .release_i (dir_rel[d]),
            .time_i    (time_now),
            .valid_o   (dir_valid[d]),
            .cap_o     (dir_cap[d])
        );
    end

    always_comb begin
        tx_cap   = dir_cap[DIR_TX];
        rx_cap   = dir_cap[DIR_RX];
        tx_valid = dir_valid[DIR_TX];
        rx_valid = dir_valid[DIR_RX];
        sel_cap  = rd_sel[1] ? rx_cap : tx_cap;
        rd_data  = rd_sel[0] ? sel_cap[WORD_W +: WORD_W] : sel_cap[0 +: WORD_W];
    end

endmodule

// File: rtl/ptp_stamp_latch_chk.sv
module ptp_stamp_latch_chk #(
    parameter int TS_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tx_en,
    input logic            rx_en,
    input logic            tx_sof,
    input logic            tx_stamp_req,
    input logic            rx_hit,
    input logic            rd_en,
    input logic [1:0]      rd_sel,
    input logic            tx_valid,
    input logic            rx_valid,
    input logic [TS_W-1:0] time_now,
    input logic [TS_W-1:0] rx_cap
);
    AST_TX_SET_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en && !tx_valid && tx_sof && tx_stamp_req && $past(tx_en) |=> tx_valid); // R2

    AST_RX_CAP_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && !rx_valid && rx_hit && $past(rx_en) |=> rx_cap == $past(time_now)); // R2

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && $past(rx_valid) |-> $stable(rx_cap)); // R3

    AST_HI_READ_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && rd_sel == 2'd3 |=> !rx_valid); // R4

    AST_LO_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && rx_valid && rd_en && rd_sel == 2'd2 |=> rx_valid); // R4

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_valid); // R5

endmodule

bind ptp_stamp_latch ptp_stamp_latch_chk #(.TS_W(TS_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_en        (tx_en),
    .rx_en        (rx_en),
    .tx_sof       (tx_sof),
    .tx_stamp_req (tx_stamp_req),
    .rx_hit       (rx_hit),
    .rd_en        (rd_en),
    .rd_sel       (rd_sel),
    .tx_valid     (tx_valid),
    .rx_valid     (rx_valid),
    .time_now     (time_now),
    .rx_cap       (rx_cap)
);

// File: tb/test_ptp_stamp_latch.sv
module test_ptp_stamp_latch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] tnow = 64'h0000_00A5_0000_1000;
    logic        tx_en = 0, rx_en = 0;
    logic [1:0]  rx_mode = 2'd3;
    logic        v1_msg_sel = 0, l2_filt_en = 0, l2_filt_ts = 0;
    logic        l4_filt_en = 0, l4_src_chk = 0;
    logic        tx_sof = 0, tx_stamp_req = 0, rx_sof = 0;
    logic [15:0] rx_ethertype = 0, rx_dst_port = 0, rx_src_port = 0;
    logic        rx_is_udp = 0;
    logic [3:0]  rx_ptp_ver = 0, rx_msg_type = 0;
    logic        rd_en = 0;
    logic [1:0]  rd_sel = 0;
    logic [31:0] rd_data;
    logic        tx_valid, rx_valid;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] exp_t;

    always #5 clk = ~clk;
    always @(posedge clk) tnow <= tnow + 64'd8;

    ptp_stamp_latch i_ptp_stamp_latch (
        .clk(clk), .rst_n(rst_n), .time_now(tnow), .tx_en(tx_en), .rx_en(rx_en),
        .rx_mode(rx_mode), .v1_msg_sel(v1_msg_sel), .l2_filt_en(l2_filt_en),
        .l2_filt_ts(l2_filt_ts), .l4_filt_en(l4_filt_en), .l4_src_chk(l4_src_chk),
        .tx_sof(tx_sof), .tx_stamp_req(tx_stamp_req), .rx_sof(rx_sof),
        .rx_ethertype(rx_ethertype), .rx_is_udp(rx_is_udp), .rx_dst_port(rx_dst_port),
        .rx_src_port(rx_src_port), .rx_ptp_ver(rx_ptp_ver), .rx_msg_type(rx_msg_type),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .tx_valid(tx_valid), .rx_valid(rx_valid)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic peek(input logic [1:0] sel, output logic [31:0] w);
        rd_sel = sel;
        #1;
        w = rd_data;
    endtask

    task automatic strobe(input logic [1:0] sel);
        @(negedge clk);
        rd_en = 1'b1;
        rd_sel = sel;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tx_frame(input logic req);
        @(negedge clk);
        tx_sof = 1'b1;
        tx_stamp_req = req;
        exp_t = tnow;
        @(negedge clk);
        tx_sof = 1'b0;
        tx_stamp_req = 1'b0;
    endtask

    task automatic rx_frame(input logic [15:0] eth, input logic udp, input logic [15:0] dst,
                            input logic [15:0] src, input logic [3:0] ver, input logic [3:0] typ);
        @(negedge clk);
        rx_ethertype = eth; rx_is_udp = udp; rx_dst_port = dst; rx_src_port = src;
        rx_ptp_ver = ver; rx_msg_type = typ;
        rx_sof = 1'b1;
        exp_t = tnow;
        @(negedge clk);
        rx_sof = 1'b0;
    endtask

    task automatic set_rx(input logic [1:0] mode);
        @(negedge clk);
        rx_mode = mode;
        rx_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] w;
        chk("R1 tx_valid", 64'(tx_valid), 64'd0);
        chk("R1 rx_valid", 64'(rx_valid), 64'd0);
        peek(2'd3, w);
        chk("R1 rx hi word", 64'(w), 64'd0);
    endtask

    task automatic t_tx();
        logic [31:0] lo, hi;
        logic [63:0] first;
        @(negedge clk); tx_en = 1'b1; @(negedge clk);
        tx_frame(1'b0);
        chk("R2 unmarked frame", 64'(tx_valid), 64'd0);
        tx_frame(1'b1);
        first = exp_t;
        chk("R2 tx valid", 64'(tx_valid), 64'd1);
        peek(2'd0, lo); peek(2'd1, hi);
        chk("R2 tx capture", {hi, lo}, first);
        tx_frame(1'b1);
        peek(2'd0, lo); peek(2'd1, hi);
        chk("R3 tx locked value", {hi, lo}, first);
        strobe(2'd0);
        chk("R4 low read keeps", 64'(tx_valid), 64'd1);
        strobe(2'd1);
        chk("R4 high read frees", 64'(tx_valid), 64'd0);
    endtask

    task automatic t_disable();
        set_rx(2'd2);
        rx_frame(16'h0, 0, 0, 0, 0, 0);
        chk("R10 all mode stamps", 64'(rx_valid), 64'd1);
        @(negedge clk); rx_en = 1'b0; @(negedge clk);
        chk("R5 disable clears", 64'(rx_valid), 64'd0);
        rx_frame(16'h0, 0, 0, 0, 0, 0);
        chk("R5 no capture disabled", 64'(rx_valid), 64'd0);
    endtask

    task automatic t_l2();
        logic [31:0] lo, hi;
        l2_filt_en = 1; l2_filt_ts = 1; l4_filt_en = 0;
        set_rx(2'd1);
        rx_frame(16'h88F7, 0, 0, 0, 4'd2, 4'd0);
        chk("R6 l2 match", 64'(rx_valid), 64'd1);
        peek(2'd2, lo); peek(2'd3, hi);
        chk("R6 rx capture", {hi, lo}, exp_t);
        strobe(2'd3);
        l2_filt_ts = 0;
        rx_frame(16'h88F7, 0, 0, 0, 4'd2, 4'd0);
        chk("R6 ts bit clear", 64'(rx_valid), 64'd0);
        l2_filt_ts = 1;
        rx_frame(16'h0800, 0, 0, 0, 4'd2, 4'd0);
        chk("R6 wrong ethertype", 64'(rx_valid), 64'd0);
        l2_filt_en = 0;
        rx_frame(16'h88F7, 0, 0, 0, 4'd2, 4'd0);
        chk("R6 filter disabled", 64'(rx_valid), 64'd0);
    endtask

    task automatic t_l4();
        l4_filt_en = 1; l4_src_chk = 0;
        rx_frame(16'h0800, 1, 16'd319, 16'd50, 4'd2, 4'd1);
        chk("R7 udp port match", 64'(rx_valid), 64'd1);
        strobe(2'd3);
        rx_frame(16'h0800, 0, 16'd319, 16'd319, 4'd2, 4'd1);
        chk("R7 not udp", 64'(rx_valid), 64'd0);
        rx_frame(16'h0800, 1, 16'd320, 16'd319, 4'd2, 4'd1);
        chk("R7 wrong dst port", 64'(rx_valid), 64'd0);
        l4_src_chk = 1;
        rx_frame(16'h0800, 1, 16'd319, 16'd50, 4'd2, 4'd1);
        chk("R7 src check rejects", 64'(rx_valid), 64'd0);
        rx_frame(16'h0800, 1, 16'd319, 16'd319, 4'd2, 4'd1);
        chk("R7 src check passes", 64'(rx_valid), 64'd1);
        strobe(2'd3);
        l4_src_chk = 0;
    endtask

    task automatic t_v2_types();
        rx_frame(16'h0800, 1, 16'd319, 16'd0, 4'd2, 4'd8);
        chk("R9 type 8 ignored", 64'(rx_valid), 64'd0);
        rx_frame(16'h0800, 1, 16'd319, 16'd0, 4'd2, 4'd3);
        chk("R9 type 3 stamped", 64'(rx_valid), 64'd1);
        strobe(2'd3);
        rx_frame(16'h0800, 1, 16'd319, 16'd0, 4'd1, 4'd0);
        chk("R9 v1 frame in v2 mode", 64'(rx_valid), 64'd0);
    endtask

    task automatic t_v1();
        v1_msg_sel = 0;
        set_rx(2'd0);
        rx_frame(16'h0800, 1, 16'd319, 16'd0, 4'd1, 4'd0);
        chk("R8 v1 sync", 64'(rx_valid), 64'd1);
        strobe(2'd3);
        v1_msg_sel = 1;
        rx_frame(16'h0800, 1, 16'd319, 16'd0, 4'd1, 4'd0);
        chk("R8 sync rejected", 64'(rx_valid), 64'd0);
        rx_frame(16'h0800, 1, 16'd319, 16'd0, 4'd1, 4'd1);
        chk("R8 delay_req", 64'(rx_valid), 64'd1);
        strobe(2'd3);
        rx_frame(16'h0800, 1, 16'd319, 16'd0, 4'd2, 4'd1);
        chk("R8 v2 in v1 mode", 64'(rx_valid), 64'd0);
    endtask

    task automatic t_modes();
        set_rx(2'd3);
        rx_frame(16'h88F7, 1, 16'd319, 16'd319, 4'd2, 4'd0);
        chk("R10 mode none", 64'(rx_valid), 64'd0);
        set_rx(2'd2);
        rx_frame(16'h1234, 0, 16'd7, 16'd7, 4'd0, 4'd15);
        chk("R10 all mode any frame", 64'(rx_valid), 64'd1);
    endtask

    task automatic t_collide();
        logic [31:0] lo, hi;
        logic [63:0] first;
        peek(2'd2, lo); peek(2'd3, hi);
        first = {hi, lo};
        chk("R3 held value is capture", first, exp_t);
        rx_frame(16'h0, 0, 0, 0, 0, 0);
        peek(2'd2, lo); peek(2'd3, hi);
        chk("R3 rx locked value", {hi, lo}, first);
        @(negedge clk);
        rd_en = 1; rd_sel = 2'd3; rx_sof = 1;
        @(negedge clk);
        rd_en = 0; rx_sof = 0;
        chk("R11 release wins", 64'(rx_valid), 64'd0);
        peek(2'd2, lo); peek(2'd3, hi);
        chk("R11 old capture kept", {hi, lo}, first);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tx();
        t_disable();
        t_l2();
        t_l4();
        t_v2_types();
        t_v1();
        t_modes();
        t_collide();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule